// File: doc/BRIEF.md
# SCL Minimum-Time and Bus-Timeout Timer

This block paces an I2C engine. It counts machine cycles and reports when the shortest allowed SCL high or low time has passed. The same measure also serves as the setup time for start and stop conditions. A machine cycle is a fixed number of core clocks, produced by a prescaler inside the block.

At every SCL transition the counter is loaded with eight minus a count chosen by a 2-bit speed code, so the minimum time has elapsed once the count reaches eight. Start and stop conditions clear the counter. While the engine is enabled, the run bit is set and a bus frame is in progress, the whole counter advances. If it wraps past its top value, the bus is treated as hung. The block then sets a sticky overflow flag and gives a one-cycle pulse that the engine uses to drop its slave-enable and master-request bits.

With the run bit low, only the three low-order bits advance. This still measures the minimum time, but a timeout can never occur. With every enable bit low, the counter is held clear.

Top module: `scl_guard_timer`

## Requirements
- R1: After an SCL transition, `min_ok_o` rises exactly N machine cycles later, where the speed code `speed_i` gives N: 2'b10 gives 7, 2'b01 gives 6, 2'b00 gives 5 and 2'b11 gives 4.
- R2: One machine cycle is PRESCALE core clocks (default 6). The prescaler restarts on every SCL transition, start, stop and while the engine is disabled, so each measured interval is a whole number of machine cycles.
- R3: The whole counter advances when the engine is enabled, `run_i` is 1 and `frame_i` is 1. If no SCL transition, start or stop then occurs, the overflow flag sets 1016+N machine cycles after the last SCL transition: 1023 for code 10, 1022 for 01, 1021 for 00 and 1020 for 11.
- R4: `tmo_pulse_o` is high for exactly one clock, on the same edge at which the overflow flag sets.
- R5: A start or stop event (`start_i` or `stop_i`) clears the counter to 0. `min_ok_o` then rises 8 machine cycles later, and a timeout follows 1024 machine cycles later.
- R6: With `slave_en_i`, `master_req_i` and `master_i` all 0, the counter is held at 0 whatever `run_i` says. `min_ok_o` stays 0, SCL transitions have no effect and no timeout occurs.
- R7: With the engine enabled and `run_i` = 0, `min_ok_o` still rises N machine cycles after an SCL transition, but no timeout ever occurs.
- R8: With `frame_i` = 0, the upper bits stand still and no timeout occurs.
- R9: The overflow flag stays set until a `clr_flag_i` strobe, which clears it on the next edge. If a timeout and the strobe fall on the same edge, setting wins.
- R10: `min_ok_o` stays set until the next SCL transition, start, stop or disable. Any of these clears it on the next edge.
- R11: Under reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en_i | input | 1 | Engine slave functions enabled |
| master_req_i | input | 1 | Mastership requested |
| master_i | input | 1 | Engine currently master |
| run_i | input | 1 | Lets the upper counter bits run for hung-bus detection |
| frame_i | input | 1 | A bus frame is in progress |
| speed_i | input | 2 | Speed code selecting the minimum count |
| scl_edge_i | input | 1 | One-clock pulse on any SCL transition |
| start_i | input | 1 | One-clock pulse on a detected start condition |
| stop_i | input | 1 | One-clock pulse on a detected stop condition |
| clr_flag_i | input | 1 | Write-one strobe clearing the overflow flag |
| min_ok_o | output | 1 | Minimum SCL high/low or setup time has elapsed |
| ovf_flag_o | output | 1 | Sticky bus-timeout flag |
| tmo_pulse_o | output | 1 | One-clock timeout pulse that drops slave enable and master request |

## Verification
The bench builds the block with its default parameters: a 10-bit counter, a three-bit minimum-time field and a divide-by-6 prescaler. These values make every timeout length for the four speed codes (1020 to 1023 machine cycles, at most about 6,100 clocks) reachable in full. Each interval is checked on the exact edge where it ends and on the edge before. Long idle stretches with the run bit low, with no frame, and with the engine disabled show that the frozen upper bits never produce a timeout.

// File: rtl/scl_guard_pkg.sv
package scl_guard_pkg;

  typedef enum logic [1:0] {
    SPD_N5 = 2'b00,
    SPD_N6 = 2'b01,
    SPD_N7 = 2'b10,
    SPD_N4 = 2'b11
  } speed_e;

  function automatic logic [3:0] min_cycles(input logic [1:0] code);
    logic [3:0] n;
    case (speed_e'(code))
      SPD_N7:  n = 4'd7;
      SPD_N6:  n = 4'd6;
      SPD_N5:  n = 4'd5;
      default: n = 4'd4;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/scl_cycle_prescaler.sv
module scl_cycle_prescaler #(
  parameter int PRESCALE = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] div_q, div_d;
  logic            at_last;

  assign at_last = (div_q == LAST);

  always_comb begin
    div_d = div_q;
    if (restart_i)    div_d = '0;
    else if (at_last) div_d = '0;
    else              div_d = div_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = at_last;
endmodule

// File: rtl/scl_mintime_core.sv
module scl_mintime_core
  import scl_guard_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int MIN_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       full_i,
  input  logic       clear_i,
  input  logic       scl_edge_i,
  input  logic       tick_i,
  input  logic [1:0] speed_i,
  output logic       min_ok_o,
  output logic       wrap_o
);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(1 << MIN_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [MIN_W:0]   low_sum;
  logic [CNT_W:0]   full_sum;
  logic [CNT_W-1:0] preload;
  logic             wrap_d;

  assign preload  = BASE - CNT_W'(min_cycles(speed_i));
  assign low_sum  = {1'b0, cnt_q[MIN_W-1:0]} + (MIN_W+1)'(1);
  assign full_sum = {1'b0, cnt_q} + (CNT_W+1)'(1);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    wrap_d = 1'b0;
    if (!en_i || clear_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (scl_edge_i) begin
      cnt_d  = preload;
      done_d = 1'b0;
    end else if (tick_i) begin
      if (low_sum[MIN_W]) done_d = 1'b1;
      if (full_i) begin
        cnt_d  = full_sum[CNT_W-1:0];
        wrap_d = full_sum[CNT_W];
      end else begin
        cnt_d = {cnt_q[CNT_W-1:MIN_W], low_sum[MIN_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign min_ok_o = done_q;
  assign wrap_o   = wrap_d;
endmodule

// File: rtl/scl_tmo_flag.sv
module scl_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic pulse_o
);
  logic ovf_q, ovf_d, pulse_q;

  always_comb begin
    ovf_d = ovf_q;
    if (wrap_i)     ovf_d = 1'b1;
    else if (clr_i) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ovf_q   <= ovf_d;
      pulse_q <= wrap_i;
    end
  end

  assign ovf_o   = ovf_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/scl_guard_timer.sv
module scl_guard_timer #(
  parameter int CNT_W    = 10,
  parameter int MIN_W    = 3,
  parameter int PRESCALE = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slave_en_i,
  input  logic       master_req_i,
  input  logic       master_i,
  input  logic       run_i,
  input  logic       frame_i,
  input  logic [1:0] speed_i,
  input  logic       scl_edge_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       clr_flag_i,
  output logic       min_ok_o,
  output logic       ovf_flag_o,
  output logic       tmo_pulse_o
);
  logic rst_n_s;
  logic en, full_run, bus_evt, restart, tick, wrap;

  assign en       = slave_en_i | master_req_i | master_i;
  assign full_run = run_i & frame_i;
  assign bus_evt  = start_i | stop_i;
  assign restart  = ~en | bus_evt | scl_edge_i;

  scl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  scl_cycle_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .restart_i (restart),
    .tick_o    (tick)
  );

  scl_mintime_core #(.CNT_W(CNT_W), .MIN_W(MIN_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en_i       (en),
    .full_i     (full_run),
    .clear_i    (bus_evt),
    .scl_edge_i (scl_edge_i),
    .tick_i     (tick),
    .speed_i    (speed_i),
    .min_ok_o   (min_ok_o),
    .wrap_o     (wrap)
  );

  scl_tmo_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wrap_i  (wrap),
    .clr_i   (clr_flag_i),
    .ovf_o   (ovf_flag_o),
    .pulse_o (tmo_pulse_o)
  );
endmodule

// File: rtl/scl_guard_timer_chk.sv
module scl_guard_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic slave_en_i,
  input logic master_req_i,
  input logic master_i,
  input logic run_i,
  input logic frame_i,
  input logic scl_edge_i,
  input logic start_i,
  input logic stop_i,
  input logic clr_flag_i,
  input logic min_ok_o,
  input logic ovf_flag_o,
  input logic tmo_pulse_o
);
  logic active;
  assign active = slave_en_i | master_req_i | master_i;

  // R6: a disabled engine yields neither minimum-time nor timeout
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!min_ok_o && !tmo_pulse_o));

  // R10: SCL transition restarts the minimum-time measure
  a_r10_edge_clears_min: assert property (@(posedge clk) disable iff (!rst_n)
    (active && scl_edge_i) |=> !min_ok_o);

  // R5: start or stop clears the count
  a_r5_evt_clears_min: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> !min_ok_o);

  // R3, R7, R8: a timeout needs full counting in the cycle before
  a_r3_tmo_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse_o |-> $past(run_i && frame_i && active));

  // R4: pulse coincides with flag and lasts one clock
  a_r4_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse_o |-> ovf_flag_o);
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse_o |=> !tmo_pulse_o);

  // R9: flag rises only with a timeout, clears after the strobe
  a_r9_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> tmo_pulse_o);
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag_i |=> (!ovf_flag_o || tmo_pulse_o));
endmodule

bind scl_guard_timer scl_guard_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slave_en_i   (slave_en_i),
  .master_req_i (master_req_i),
  .master_i     (master_i),
  .run_i        (run_i),
  .frame_i      (frame_i),
  .scl_edge_i   (scl_edge_i),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .clr_flag_i   (clr_flag_i),
  .min_ok_o     (min_ok_o),
  .ovf_flag_o   (ovf_flag_o),
  .tmo_pulse_o  (tmo_pulse_o)
);

// File: tb/tb_scl_guard_timer.sv
module tb_scl_guard_timer;
  localparam int PS = 6;

  logic       clk, rst_n;
  logic       slave_en, master_req, master, run, frame;
  logic [1:0] speed;
  logic       scl_edge, start, stop, clr;
  logic       min_ok, ovf, tmo;

  int checks = 0;
  int errors = 0;
  int tmo_seen = 0;
  bit done = 0;

  scl_guard_timer #(.CNT_W(10), .MIN_W(3), .PRESCALE(PS)) dut (
    .clk(clk), .rst_n(rst_n),
    .slave_en_i(slave_en), .master_req_i(master_req), .master_i(master),
    .run_i(run), .frame_i(frame), .speed_i(speed),
    .scl_edge_i(scl_edge), .start_i(start), .stop_i(stop),
    .clr_flag_i(clr),
    .min_ok_o(min_ok), .ovf_flag_o(ovf), .tmo_pulse_o(tmo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && tmo) tmo_seen <= tmo_seen + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_scl();
    scl_edge = 1'b1; @(negedge clk); scl_edge = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    slave_en = 0; master_req = 0; master = 0; run = 0; frame = 0;
    speed = 2'b00; scl_edge = 0; start = 0; stop = 0; clr = 0;
    wait_n(3);
    chk("R11 min_ok", min_ok, 0);
    chk("R11 ovf", ovf, 0);
    chk("R11 tmo", tmo, 0);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  task automatic t_min_time(input logic [1:0] code, input int n);
    slave_en = 1; run = 1; frame = 1; speed = code;
    @(negedge clk);
    pulse_scl();
    chk("R10 cleared by edge", min_ok, 0);
    wait_n(PS*n - 1);
    chk("R1 R2 before min", min_ok, 0);
    wait_n(1);
    chk("R1 R2 at min", min_ok, 1);
    wait_n(20);
    chk("R10 min held", min_ok, 1);
  endtask

  task automatic t_timeout(input logic [1:0] code, input int n);
    int t;
    t = PS * (1016 + n);
    slave_en = 1; run = 1; frame = 1; speed = code;
    pulse_clr();
    pulse_scl();
    wait_n(t - 1);
    chk("R3 no flag before", ovf, 0);
    chk("R4 no pulse before", tmo, 0);
    wait_n(1);
    chk("R3 flag at timeout", ovf, 1);
    chk("R4 pulse at timeout", tmo, 1);
    wait_n(1);
    chk("R4 pulse one clock", tmo, 0);
    chk("R9 flag sticky", ovf, 1);
  endtask

  task automatic t_start_stop();
    slave_en = 1; run = 1; frame = 1; speed = 2'b11;
    pulse_clr();
    chk("R9 flag cleared", ovf, 0);
    pulse_scl();
    wait_n(10);
    start = 1; @(negedge clk); start = 0;
    wait_n(PS*8 - 1);
    chk("R5 before 8", min_ok, 0);
    wait_n(1);
    chk("R5 at 8", min_ok, 1);
    stop = 1; @(negedge clk); stop = 0;
    chk("R5 R10 stop clears", min_ok, 0);
    wait_n(PS*1024 - 1);
    chk("R5 no flag before 1024", ovf, 0);
    wait_n(1);
    chk("R5 flag at 1024", ovf, 1);
    pulse_clr();
    chk("R9 clear after strobe", ovf, 0);
  endtask

  task automatic t_low_only();
    int base;
    slave_en = 0; master_req = 1; run = 0; frame = 1; speed = 2'b11;
    base = tmo_seen;
    pulse_scl();
    wait_n(PS*4 - 1);
    chk("R7 before min", min_ok, 0);
    wait_n(1);
    chk("R7 at min", min_ok, 1);
    wait_n(PS*1100);
    chk("R7 no flag", ovf, 0);
    chk("R7 no pulse", tmo_seen - base, 0);
    master_req = 0;
  endtask

  task automatic t_no_frame();
    int base;
    master = 1; run = 1; frame = 0; speed = 2'b10;
    base = tmo_seen;
    pulse_scl();
    wait_n(PS*7);
    chk("R8 min still measured", min_ok, 1);
    wait_n(PS*1100);
    chk("R8 no flag", ovf, 0);
    chk("R8 no pulse", tmo_seen - base, 0);
    master = 0;
  endtask

  task automatic t_disabled();
    int base;
    slave_en = 0; master_req = 0; master = 0; run = 1; frame = 1;
    speed = 2'b11;
    base = tmo_seen;
    @(negedge clk);
    chk("R6 min cleared", min_ok, 0);
    pulse_scl();
    wait_n(PS*10);
    chk("R6 edge ignored", min_ok, 0);
    wait_n(PS*1100);
    chk("R6 no flag", ovf, 0);
    chk("R6 no pulse", tmo_seen - base, 0);
  endtask

  initial begin
    t_reset();
    t_min_time(2'b10, 7);
    t_min_time(2'b01, 6);
    t_min_time(2'b00, 5);
    t_min_time(2'b11, 4);
    t_timeout(2'b10, 7);
    t_timeout(2'b01, 6);
    t_timeout(2'b00, 5);
    t_timeout(2'b11, 4);
    t_start_stop();
    t_low_only();
    t_no_frame();
    t_disabled();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule